// File: doc/BRIEF.md
# Sampled Programmable Delay Line

This block reproduces a single-bit input on its output, not inverted, after a number of reference-clock periods chosen by an 8-bit setting. Every cycle the input is sampled into a history shift register. The output is taken from a tap of that register. The total delay is a fixed base of `INH` cycles plus the setting times `STEP` cycles. Rising and falling edges go through the same path, so a pulse that gets through keeps its width.

A width gate sits behind the tap. A level reaches the output only after it has lasted a minimum number of cycles. That minimum grows with the setting, at two fifths of the programmed part of the delay, and never drops below a floor. Narrower pulses of either polarity are swallowed, not distorted. The tap is placed earlier than the total delay by exactly that minimum, so the gate does not change the end-to-end latency.

When the setting changes, the output freezes at its last value for a time equal to the new total delay. After that it follows the stream delayed by the new amount. The setting comes from a separate interface block and is read directly every cycle.

Top module: `prog_delay_line`

## Requirements
- R1: While `rst_n` is low, `dout` is 0, the sample history is all zeros and the active setting is 0.
- R2: With a steady setting `a`, a level sampled on `din` at rising edge `s` appears on `dout` right after edge `s + INH + a*STEP`, with the same polarity.
- R3: Setting 0 gives the shortest delay, exactly `INH` cycles.
- R4: Rising and falling transitions get the same delay, so a pulse of `P` cycles that passes leaves `dout` for exactly `P` cycles.
- R5: The minimum width is `W(a) = max(PW_FLOOR, floor(a*STEP*PW_NUM/PW_DEN))`, with defaults 2 and 2/5. A pulse of at least `W(a)` cycles passes. A pulse of fewer cycles never changes `dout`.
- R6: At the first edge where `addr` differs from the active setting, the new value becomes active. `dout` then keeps the value it had before that edge until edge `e0 + INH + a_new*STEP`. From that edge on, it shows the stream delayed by the new setting.
- R7: If the setting changes again during a hold, the hold restarts from the newest change, with a length equal to the newest total delay.
- R8: The width gate works for both polarities: a low gap shorter than `W(a)` inside a high level is suppressed, and one of `W(a)` cycles or more passes.
- R9: At setting 255 the delay is `INH + 255*STEP` and the minimum width is `W(255)`, using the full history depth `INH + 255*STEP`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Delay setting from the interface block |
| din | input | 1 | Signal to be delayed |
| dout | output | 1 | Delayed, width-gated copy of `din` |

## Verification
The bench drives pulses exactly one cycle shorter than the minimum width and pulses exactly at it, at several settings. A gate with an off-by-one in its run counter would let the short pulse through or drop the legal one. Pulses are sent at settings 0 and 255, so a tap index that is off by one, or that overruns the history at the top end, shows up as an edge one cycle early or late.

One pulse is sent while the setting changes mid-flight. A design that does not freeze would show the new-delay edge several cycles early. A design that freezes for the old delay, or that ignores a second change during a hold, would show the first edge at the wrong cycle.

A low gap inside a high level checks that the gate treats both polarities alike.

// File: rtl/dlyl_pkg.sv
package dlyl_pkg;

   // Total latency in clock cycles for a given setting.
   function automatic int unsigned total_cycles(input int unsigned a,
                                                input int unsigned base,
                                                input int unsigned step);
      return base + a * step;
   endfunction

   // Shortest level run that the width gate lets through.
   function automatic int unsigned gate_cycles(input int unsigned a,
                                               input int unsigned step,
                                               input int unsigned num,
                                               input int unsigned den,
                                               input int unsigned flo);
      int unsigned scaled;
      scaled = (a * step * num) / den;
      return (scaled < flo) ? flo : scaled;
   endfunction

endpackage

// File: rtl/dlyl_history.sv
module dlyl_history #(
   parameter int unsigned DEPTH = 259,
   parameter int unsigned IW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          din,
   input  logic [IW-1:0] tap_idx,
   output logic          tap
);

   logic [DEPTH-1:0] hist_q;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dlyl_history: DEPTH must be at least 2");
      end
   endgenerate

   // Entry k holds the sample taken k edges before the most recent one.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= {hist_q[DEPTH-2:0], din};
   end

   assign tap = hist_q[tap_idx];

   // R2
   tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tap_idx) < DEPTH)
      else $error("tap index beyond history depth");

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (hist_q == '0))
      else $error("history not cleared in reset");

endmodule

// File: rtl/dlyl_setting.sv
module dlyl_setting
   import dlyl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned INH      = 4,
   parameter int unsigned STEP     = 1,
   parameter int unsigned PW_FLOOR = 2,
   parameter int unsigned PW_NUM   = 2,
   parameter int unsigned PW_DEN   = 5,
   parameter int unsigned DEPTH    = 259,
   parameter int unsigned DW       = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              addr_chg,
   output logic [DW-1:0]     tap_idx,
   output logic [DW-1:0]     min_w,
   output logic [DW-1:0]     hold_left
);

   logic [ADDR_W-1:0] act_q;
   logic [DW-1:0]     tot_q, wid_q, cnt_q;
   logic [DW-1:0]     tot_new, wid_new;

   assign addr_chg = (addr != act_q);
   assign tot_new  = DW'(total_cycles(32'(addr), INH, STEP));

   generate
      if (PW_NUM == 0) begin : g_fixed_gate
         assign wid_new = DW'(PW_FLOOR);
      end else begin : g_scaled_gate
         assign wid_new = DW'(gate_cycles(32'(addr), STEP, PW_NUM, PW_DEN, PW_FLOOR));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         tot_q <= DW'(INH);
         wid_q <= DW'(PW_FLOOR);
         cnt_q <= '0;
      end else if (addr_chg) begin
         act_q <= addr;
         tot_q <= tot_new;
         wid_q <= wid_new;
         cnt_q <= tot_new;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // Tap sits early by the gate width so the gate adds no net latency.
   assign tap_idx   = tot_q - wid_q;
   assign min_w     = wid_q;
   assign hold_left = cnt_q;

   // R6
   hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= tot_q)
      else $error("hold longer than total delay");

   // R7
   hold_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_chg |=> (cnt_q == tot_q) && (act_q == $past(addr)))
      else $error("hold not restarted on setting change");

   // R5
   gate_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wid_q <= tot_q) && (wid_q >= DW'(PW_FLOOR)))
      else $error("gate width outside legal range");

   // R2
   tot_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tot_q) <= DEPTH)
      else $error("total delay exceeds history");

endmodule

// File: rtl/dlyl_pulse_gate.sv
module dlyl_pulse_gate #(
   parameter int unsigned CW    = 9,
   parameter int unsigned MAX_W = 102
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tap,
   input  logic [CW-1:0] min_w,
   output logic          lvl
);

   logic [CW-1:0] run_q;
   logic          lvl_q;

   // Count cycles the tap disagrees with the output; flip once the run is long enough.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         run_q <= '0;
      end else if (tap == lvl_q) begin
         run_q <= '0;
      end else if (run_q + 1'b1 >= min_w) begin
         lvl_q <= tap;
         run_q <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign lvl = lvl_q;

   // R5
   agree_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tap == lvl_q) |=> $stable(lvl_q))
      else $error("gate output moved while tap agreed");

   // R8
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(run_q) < MAX_W)
      else $error("run counter beyond widest gate");

   // R4
   flip_follows_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tap != lvl_q) && (run_q + 1'b1 >= min_w) |=> (lvl_q == $past(tap)))
      else $error("gate flipped to wrong level");

endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
   import dlyl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned INH      = 4,
   parameter int unsigned STEP     = 1,
   parameter int unsigned PW_FLOOR = 2,
   parameter int unsigned PW_NUM   = 2,
   parameter int unsigned PW_DEN   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              din,
   output logic              dout
);

   localparam int unsigned MAXA  = (1 << ADDR_W) - 1;
   localparam int unsigned DEPTH = INH + MAXA * STEP;
   localparam int unsigned DW    = $clog2(DEPTH + 1);
   localparam int unsigned IW    = $clog2(DEPTH);
   localparam int unsigned MAX_W = gate_cycles(MAXA, STEP, PW_NUM, PW_DEN, PW_FLOOR);

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
         $error("prog_delay_line: ADDR_W out of range");
      end
      if (STEP < 1) begin : g_bad_step
         $error("prog_delay_line: STEP must be positive");
      end
      if (PW_FLOOR < 1 || INH < PW_FLOOR) begin : g_bad_floor
         $error("prog_delay_line: need 1 <= PW_FLOOR <= INH");
      end
      if (PW_DEN < 1 || PW_NUM > PW_DEN) begin : g_bad_ratio
         $error("prog_delay_line: gate ratio must not exceed one");
      end
      if (DEPTH > 4096) begin : g_bad_depth
         $error("prog_delay_line: history too deep");
      end
   endgenerate

   logic          addr_chg;
   logic [DW-1:0] tap_idx, min_w, hold_left;
   logic          tap, gate_lvl, held_q;

   dlyl_setting #(
      .ADDR_W(ADDR_W), .INH(INH), .STEP(STEP), .PW_FLOOR(PW_FLOOR),
      .PW_NUM(PW_NUM), .PW_DEN(PW_DEN), .DEPTH(DEPTH), .DW(DW)
   ) u_setting (
      .clk(clk), .rst_n(rst_n), .addr(addr), .addr_chg(addr_chg),
      .tap_idx(tap_idx), .min_w(min_w), .hold_left(hold_left)
   );

   dlyl_history #(.DEPTH(DEPTH), .IW(IW)) u_history (
      .clk(clk), .rst_n(rst_n), .din(din), .tap_idx(tap_idx[IW-1:0]), .tap(tap)
   );

   dlyl_pulse_gate #(.CW(DW), .MAX_W(MAX_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .tap(tap), .min_w(min_w), .lvl(gate_lvl)
   );

   // Output freezes on the last shown value while a hold is running.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                held_q <= 1'b0;
      else if (hold_left == '0)  held_q <= gate_lvl;
   end

   assign dout = (hold_left != '0) ? held_q : gate_lvl;

   // R6
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_chg || hold_left >= DW'(2)) |=> $stable(dout))
      else $error("output moved during setting hold");

   // R1
   reset_out_chk: assert property (@(posedge clk)
      !rst_n |-> (dout == 1'b0))
      else $error("output not low in reset");

endmodule

// File: tb/prog_delay_line_bench.sv
module prog_delay_line_bench;

   localparam int INH = 4, STEP = 1, FLOOR = 2, NUM = 2, DEN = 5;

   typedef struct {
      int    cyc;
      bit    lvl;
      string tag;
   } ev_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = 8'd0;
   logic       din = 1'b0;
   logic       dout;

   int  cyc = 0;
   int  checks = 0;
   int  fails = 0;
   int  cur_a = 0;
   bit  prev = 1'b0;
   bit  done = 1'b0;
   ev_t exp_q[$];

   prog_delay_line #(.ADDR_W(8), .INH(INH), .STEP(STEP), .PW_FLOOR(FLOOR),
                     .PW_NUM(NUM), .PW_DEN(DEN)) u_prog_delay_line (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int d_of(input int a);
      return INH + a * STEP;
   endfunction

   function automatic int w_of(input int a);
      int w;
      w = (a * STEP * NUM) / DEN;
      return (w < FLOOR) ? FLOOR : w;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push(input int c, input bit l, input string tag);
      ev_t e;
      e.cyc = c; e.lvl = l; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Driver: sends a pulse away from the background level and predicts its edges.
   task automatic pulse(input bit lvl, input int width, input bit pass, input string tag);
      int n, d;
      n = cyc;
      d = d_of(cur_a);
      if (pass) begin
         push(n + 1 + d, lvl, tag);
         push(n + 1 + width + d, !lvl, tag);
      end
      din = lvl;
      idle(width);
      din = !lvl;
      idle(d + width + 10);
      chk(dout == !lvl, tag, "level after pulse", dout, !lvl);
   endtask

   task automatic step_to(input bit lvl, input string tag);
      push(cyc + 1 + d_of(cur_a), lvl, tag);
      din = lvl;
      idle(d_of(cur_a) + 10);
   endtask

   task automatic set_addr(input int a);
      addr = 8'(a);
      cur_a = a;
      idle(d_of(a) + 6);
   endtask

   // Monitor: every output edge must match the next predicted edge.
   always @(negedge clk) begin
      if (rst_n && !done && (dout != prev)) begin
         if (exp_q.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL unexpected: dout edge to %0d at cycle %0d, expected no edge", dout, cyc);
         end else begin
            ev_t e;
            e = exp_q.pop_front();
            chk((cyc == e.cyc) && (dout == e.lvl), e.tag, "edge cycle",
                cyc, e.cyc);
         end
         prev = dout;
      end
   end

   initial begin
      int n;
      idle(3);
      chk(dout == 1'b0, "R1", "dout in reset", dout, 0);
      idle(2);
      rst_n = 1'b1;
      idle(2);
      chk(dout == 1'b0, "R1", "dout after reset", dout, 0);

      // R3 / R2 / R4: shortest setting
      pulse(1'b1, 5, 1'b1, "R3");
      pulse(1'b1, 1, 1'b0, "R5");
      pulse(1'b1, 2, 1'b1, "R5");

      // R2 / R4 / R5 at setting 10 (delay 14, width 4)
      set_addr(10);
      chk(dout == 1'b0, "R6", "level after hold", dout, 0);
      pulse(1'b1, 4, 1'b1, "R5");
      pulse(1'b1, 3, 1'b0, "R5");
      pulse(1'b1, 9, 1'b1, "R4");

      // R8: low gaps inside a high level
      step_to(1'b1, "R2");
      pulse(1'b0, 3, 1'b0, "R8");
      pulse(1'b0, 4, 1'b1, "R8");
      step_to(1'b0, "R4");

      // R6: pulse in flight while the setting drops from 20 to 5
      set_addr(20);
      n = cyc;
      push(n + 4 + d_of(5), 1'b1, "R6");
      push(n + 1 + 10 + d_of(5), 1'b0, "R6");
      din = 1'b1;
      idle(3);
      addr = 8'd5;
      cur_a = 5;
      idle(7);
      din = 1'b0;
      idle(2);
      chk(dout == 1'b0, "R6", "held level inside hold", dout, 0);
      idle(40);

      // R7: second change restarts the hold
      n = cyc;
      addr = 8'd30;
      idle(5);
      addr = 8'd15;
      cur_a = 15;
      din = 1'b1;
      push(n + 6 + d_of(15), 1'b1, "R7");
      idle(12);
      chk(dout == 1'b0, "R7", "held level after restart", dout, 0);
      idle(40);
      step_to(1'b0, "R4");

      // R9: longest setting
      set_addr(255);
      pulse(1'b1, w_of(255), 1'b1, "R9");
      pulse(1'b1, w_of(255) - 1, 1'b0, "R9");

      chk(exp_q.size() == 0, "R2", "predicted edges left", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not end, actual=%0d expected=%0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule